// File: doc/BRIEF.md
# Down-Counting Timer Time Base

This block is the time base of a general-purpose timer. A prescaler divides the system clock into count ticks. On each tick the main counter steps down by one. When it reaches zero, the next tick reloads it from the active reload value, which is an underflow. A repetition counter sets how many underflows must pass before an update event is raised. When the update event fires, the active prescaler ratio, reload value and repetition count are taken from their preload registers. The update event also sets a sticky flag, which can raise an interrupt.

Software drives the block through a single write port. It selects one of five registers with `wr_sel`:
- control (0)
- prescaler preload (1)
- reload (2)
- repetition preload (3)
- command (4)

A command write can force an update, and it can clear the flag. Control bits enable counting, inhibit updates, keep software-forced updates from raising the flag, buffer the reload value until the next update, and enable the interrupt.

Top module: `tbase_down_timer`

## Requirements
- R1: After synchronous reset, `count_o`, `evt_o`, `flag_o` and `irq_o` are all 0, and every control bit is 0.
- R2: While control bit 0 (run) is 1, a tick occurs once every P+1 clocks, where P is the active prescaler value. Each tick lowers a non-zero count by 1. While run is 0, the count holds.
- R3: A tick at count 0 reloads the count: from the preload value when that underflow is an update, otherwise from the active reload value.
- R4: The repetition counter lowers on each underflow while it is non-zero. An underflow that finds it at zero is an update. With reload A, prescaler P and repetition R, updates therefore come every (A+1)(P+1)(R+1) clocks.
- R5: Writing a command word with bit 0 set forces an update at that clock edge. The count becomes the reload preload, the prescaler phase restarts at 0, and all active values are loaded. `evt_o` pulses high for one clock, in the cycle after the update edge.
- R6: While control bit 1 (hold) is 1, neither underflows nor forced updates produce an update. No `evt_o` pulse occurs, the active values keep their contents, and underflows still reload the count from the active reload value.
- R7: An update sets `flag_o` in the same cycle as its `evt_o` pulse. The one exception is a forced update while control bit 2 (quiet) is 1. Underflow updates set the flag whatever quiet is.
- R8: With control bit 3 (buffered reload) at 1, a reload write changes only the preload copy. The new period starts at the next update.
- R9: With buffered reload at 0, a reload write also changes the active reload value at once, so the next non-update underflow uses it.
- R10: `flag_o` stays 1 until a command word with bit 1 set clears it. If a set and a clear fall on the same edge, the set wins.
- R11: `irq_o` is 1 exactly when `flag_o` is 1 and control bit 4 (interrupt enable) is 1.
- R12: A prescaler write takes effect only at the next update. Ticks keep the old ratio until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 control, 1 prescaler, 2 reload, 3 repetition, 4 command) |
| wr_data | input | DATA_W | Write data |
| count_o | output | CNT_W | Current counter value |
| evt_o | output | 1 | One-clock update event pulse |
| flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Any wrong internal state shows at the ports within a bounded time.

- **Prescaler or repetition state:** a wrong phase moves the next `evt_o` pulse. This shows as a wrong interval between pulses within one programmed period, at most (A+1)(P+1)(R+1) clocks.
- **Active reload value:** a wrong value appears in `count_o` one tick after an underflow.
- **Preload copied too early or too late:** this changes the interval between two consecutive events.
- **Flag logic:** an error is visible on `flag_o` and `irq_o` in the cycle after the edge that set or cleared the flag.

The bench therefore measures event intervals in clocks over random settings, and checks directed cases for hold, quiet and the two reload modes.

// File: rtl/tbase_pkg.sv
`timescale 1ns/1ps
package tbase_pkg;

    // Register select codes on the write port
    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_PSC  = 3'd1,
        REG_ARR  = 3'd2,
        REG_REP  = 3'd3,
        REG_CMD  = 3'd4
    } reg_sel_e;

    // Control word, bit 0 is run (packed: last member is LSB)
    typedef struct packed {
        logic irq_en;     // bit 4
        logic arr_buf;    // bit 3
        logic quiet;      // bit 2
        logic hold_upd;   // bit 1
        logic run;        // bit 0
    } tb_ctrl_t;

    localparam int CTRL_W      = 5;
    localparam int CMD_UPD_BIT = 0;
    localparam int CMD_CLR_BIT = 1;

    function automatic tb_ctrl_t ctrl_from_bits(input logic [CTRL_W-1:0] b);
        return tb_ctrl_t'(b);
    endfunction

    function automatic logic is_cmd_bit(input logic en, input logic [2:0] sel,
                                        input logic bit_val);
        return en && (sel == REG_CMD) && bit_val;
    endfunction

endpackage

// File: rtl/tbase_regs.sv
`timescale 1ns/1ps
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int REP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              upd,
    output tb_ctrl_t          ctrl,
    output logic [PSC_W-1:0]  psc_act,
    output logic [CNT_W-1:0]  arr_act,
    output logic [CNT_W-1:0]  arr_pre,
    output logic [REP_W-1:0]  rep_pre,
    output logic              sw_upd_req,
    output logic              clr_req
);

    logic [PSC_W-1:0] psc_pre;
    logic             arr_wr;

    assign arr_wr     = wr_en && (wr_sel == REG_ARR);
    assign sw_upd_req = is_cmd_bit(wr_en, wr_sel, wr_data[CMD_UPD_BIT]);
    assign clr_req    = is_cmd_bit(wr_en, wr_sel, wr_data[CMD_CLR_BIT]);

    // Preload registers and control word
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            psc_pre <= '0;
            arr_pre <= '0;
            rep_pre <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                REG_CTRL: ctrl    <= ctrl_from_bits(wr_data[CTRL_W-1:0]);
                REG_PSC:  psc_pre <= wr_data[PSC_W-1:0];
                REG_ARR:  arr_pre <= wr_data[CNT_W-1:0];
                REG_REP:  rep_pre <= wr_data[REP_W-1:0];
                default:  ;
            endcase
        end
    end

    // Active (shadow) copies: loaded on update, or reload written through
    always_ff @(posedge clk) begin
        if (rst) begin
            psc_act <= '0;
            arr_act <= '0;
        end else if (upd) begin
            psc_act <= psc_pre;
            arr_act <= arr_pre;
        end else if (arr_wr && !ctrl.arr_buf) begin
            arr_act <= wr_data[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/tbase_presc.sv
`timescale 1ns/1ps
module tbase_presc #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc_act,
    output logic             tick
);

    logic [PSC_W-1:0] pcnt;

    assign tick = run && (pcnt == psc_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (restart) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/tbase_count.sv
`timescale 1ns/1ps
module tbase_count #(
    parameter int CNT_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             sw_req,
    input  logic             hold,
    input  logic [CNT_W-1:0] arr_act,
    input  logic [CNT_W-1:0] arr_pre,
    input  logic [REP_W-1:0] rep_pre,
    output logic [CNT_W-1:0] cnt,
    output logic             upd,
    output logic             upd_sw
);

    logic [REP_W-1:0] rep_cnt;
    logic             at_zero;
    logic             uflow;
    logic             rep_done;
    logic             hw_upd;

    assign at_zero  = (cnt == '0);
    assign uflow    = tick && at_zero;
    assign rep_done = (rep_cnt == '0);
    assign upd_sw   = sw_req && !hold;
    assign hw_upd   = uflow && rep_done && !hold;
    assign upd      = upd_sw || hw_upd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            rep_cnt <= '0;
        end else if (upd) begin
            // active reload takes the preload first, so count uses it directly
            cnt     <= arr_pre;
            rep_cnt <= rep_pre;
        end else if (tick) begin
            if (at_zero) begin
                cnt <= arr_act;
                if (!rep_done) rep_cnt <= rep_cnt - 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/tbase_flag.sv
`timescale 1ns/1ps
module tbase_flag (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic upd_sw,
    input  logic quiet,
    input  logic clr,
    input  logic irq_en,
    output logic evt,
    output logic flag,
    output logic irq
);

    logic set_flag;

    assign set_flag = upd && !(upd_sw && quiet);
    assign irq      = flag && irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt  <= 1'b0;
            flag <= 1'b0;
        end else begin
            evt <= upd;
            if (set_flag)  flag <= 1'b1;
            else if (clr)  flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tbase_down_timer.sv
`timescale 1ns/1ps
module tbase_down_timer
    import tbase_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int REP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              evt_o,
    output logic              flag_o,
    output logic              irq_o
);

    tb_ctrl_t         ctrl_q;
    logic [PSC_W-1:0] psc_act;
    logic [CNT_W-1:0] arr_act;
    logic [CNT_W-1:0] arr_pre;
    logic [REP_W-1:0] rep_pre;
    logic             sw_upd_req;
    logic             clr_req;
    logic             tick;
    logic             upd;
    logic             upd_sw;

    tbase_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .upd(upd), .ctrl(ctrl_q), .psc_act(psc_act), .arr_act(arr_act),
        .arr_pre(arr_pre), .rep_pre(rep_pre), .sw_upd_req(sw_upd_req),
        .clr_req(clr_req)
    );

    tbase_presc #(.PSC_W(PSC_W)) u_presc (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .restart(upd_sw),
        .psc_act(psc_act), .tick(tick)
    );

    tbase_count #(.CNT_W(CNT_W), .REP_W(REP_W)) u_count (
        .clk(clk), .rst(rst), .tick(tick), .sw_req(sw_upd_req),
        .hold(ctrl_q.hold_upd), .arr_act(arr_act), .arr_pre(arr_pre),
        .rep_pre(rep_pre), .cnt(count_o), .upd(upd), .upd_sw(upd_sw)
    );

    tbase_flag u_flag (
        .clk(clk), .rst(rst), .upd(upd), .upd_sw(upd_sw), .quiet(ctrl_q.quiet),
        .clr(clr_req), .irq_en(ctrl_q.irq_en), .evt(evt_o), .flag(flag_o),
        .irq(irq_o)
    );

endmodule

// File: rtl/tbase_down_timer_chk.sv
`timescale 1ns/1ps
module tbase_down_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic             clr_bit,
    input logic [CNT_W-1:0] count_o,
    input logic             evt_o,
    input logic             flag_o,
    input logic             irq_o,
    input logic             hold
);

    // R11
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag_o);

    // R7
    flag_rise_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> evt_o);

    // R6
    hold_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hold) |-> !evt_o);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(count_o) != '0 && count_o != $past(count_o) && !evt_o)
        |-> (count_o == $past(count_o) - 1'b1));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && $past(wr_sel) == 3'd4 && $past(clr_bit) && !evt_o)
        |-> !flag_o);

endmodule

bind tbase_down_timer tbase_down_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .clr_bit(wr_data[1]), .count_o(count_o), .evt_o(evt_o),
    .flag_o(flag_o), .irq_o(irq_o), .hold(ctrl_q.hold_upd)
);

// File: tb/tbase_down_timer_bench.sv
`timescale 1ns/1ps
module tbase_down_timer_bench;

    localparam int DW = 16;
    localparam int CW = 16;
    localparam int S_CTRL = 0, S_PSC = 1, S_ARR = 2, S_REP = 3, S_CMD = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] count_o;
    logic          evt_o, flag_o, irq_o;

    int vec = 0;
    int bad = 0;
    bit done = 0;

    tbase_down_timer u_tbase_down_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .count_o(count_o), .evt_o(evt_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr(input int sel, input int data);
        wr_en   = 1'b1;
        wr_sel  = sel[2:0];
        wr_data = data[DW-1:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic int ctl(input int run, input int hold, input int quiet,
                               input int bufr, input int ie);
        return run + 2*hold + 4*quiet + 8*bufr + 16*ie;
    endfunction

    function automatic int period(input int a, input int p, input int r);
        return (a+1)*(p+1)*(r+1);
    endfunction

    // clocks until evt_o, counting from the current negedge
    task automatic wait_evt(output int n);
        n = 0;
        while (!evt_o && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // clocks from the current event to the next one
    task automatic wait_next(output int n);
        n = 1;
        @(negedge clk);
        while (!evt_o && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic stop_all();
        wr(S_CTRL, 0);
        wr(S_CMD, 2);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vec++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n, a, p, r, q, ie, c0;
        bit saw;
        void'($urandom(32'h1b5e));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", int'(count_o), 0);
        chk("R1 evt", int'(evt_o), 0);
        chk("R1 flag", int'(flag_o), 0);
        chk("R1 irq", int'(irq_o), 0);

        // random configurations
        for (int i = 0; i < 10; i++) begin
            a  = int'($urandom % 8);
            p  = int'($urandom % 4);
            r  = int'($urandom % 4);
            q  = int'($urandom % 2);
            ie = int'($urandom % 2);
            wr(S_PSC, p);
            wr(S_ARR, a);
            wr(S_REP, r);
            wr(S_CTRL, ctl(0, 0, q, 1, ie));
            wr(S_CMD, 2);
            wr(S_CMD, 1);
            chk("R5 count after forced update", int'(count_o), a);
            chk("R5 evt pulse", int'(evt_o), 1);
            chk("R7 flag after forced update", int'(flag_o), q ? 0 : 1);
            chk("R11 irq after forced update", int'(irq_o), (!q && ie) ? 1 : 0);
            wr(S_CMD, 2);
            chk("R10 flag cleared", int'(flag_o), 0);
            wr(S_CTRL, ctl(1, 0, q, 1, ie));
            wait_evt(n);
            chk("R4 first period", n, period(a, p, r));
            chk("R7 underflow sets flag", int'(flag_o), 1);
            chk("R11 irq follows enable", int'(irq_o), ie);
            chk("R3 reload value", int'(count_o), a);
            wait_next(n);
            chk("R3 second period", n, period(a, p, r));
            wr(S_CTRL, ctl(0, 0, q, 1, ie));
            c0 = int'(count_o);
            repeat (5) @(negedge clk);
            chk("R2 count holds when stopped", int'(count_o), c0);
            wr(S_CMD, 2);
        end

        // R2 decrement timing with prescaler 2
        stop_all();
        wr(S_PSC, 2);
        wr(S_ARR, 5);
        wr(S_REP, 0);
        wr(S_CMD, 1);
        wr(S_CTRL, ctl(1, 0, 0, 1, 0));
        repeat (2) @(negedge clk);
        chk("R2 count before tick", int'(count_o), 5);
        @(negedge clk);
        chk("R2 count after tick", int'(count_o), 4);

        // R6 hold blocks updates
        stop_all();
        wr(S_PSC, 0);
        wr(S_ARR, 3);
        wr(S_REP, 0);
        wr(S_CMD, 1);
        wr(S_CMD, 2);
        wr(S_CTRL, ctl(1, 1, 0, 1, 0));
        saw = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (evt_o) saw = 1;
        end
        chk("R6 no event while held", int'(saw), 0);
        chk("R6 flag stays clear", int'(flag_o), 0);
        chk("R6 underflow reloads active value", int'(count_o), 3);
        wr(S_ARR, 6);
        chk("R8 buffered write not active", int'(count_o), 2);
        wr(S_CMD, 1);
        chk("R6 forced update blocked", int'(evt_o), 0);
        chk("R6 count keeps running", int'(count_o), 1);
        wr(S_CTRL, ctl(1, 0, 0, 1, 0));
        wait_evt(n);
        chk("R8 preload taken at update", int'(count_o), 6);
        wait_next(n);
        chk("R8 new period after update", n, 7);

        // R9 / R8 reload written mid-run with repetition 1
        for (int b = 0; b < 2; b++) begin
            stop_all();
            wr(S_PSC, 0);
            wr(S_ARR, 6);
            wr(S_REP, 1);
            wr(S_CTRL, ctl(0, 0, 0, b, 0));
            wr(S_CMD, 1);
            wr(S_ARR, 2);
            wr(S_CTRL, ctl(1, 0, 0, b, 0));
            wait_evt(n);
            if (b == 0) chk("R9 immediate reload write", n, 10);
            else        chk("R8 buffered reload write", n, 14);
        end

        // R12 prescaler preload
        stop_all();
        wr(S_PSC, 1);
        wr(S_ARR, 1);
        wr(S_REP, 0);
        wr(S_CTRL, ctl(0, 0, 0, 1, 0));
        wr(S_CMD, 1);
        wr(S_PSC, 3);
        wr(S_CTRL, ctl(1, 0, 0, 1, 0));
        wait_evt(n);
        chk("R12 old ratio until update", n, 4);
        wait_next(n);
        chk("R12 new ratio after update", n, 8);
        wr(S_CTRL, ctl(0, 0, 0, 1, 0));
        repeat (3) @(negedge clk);
        chk("R10 flag sticky", int'(flag_o), 1);
        wr(S_CMD, 2);
        chk("R10 flag cleared by command", int'(flag_o), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule